// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is one timer channel. Software programs it over a simple synchronous register bus clocked by the bus clock `pclk`. The counter runs in a separate, slower timer clock `tclk` and moves only on a prescaled tick. Software writes a 32-bit interval and a control word holding enable, reload request, prescale select and mode. The counter then steps down from the interval to zero. On reaching zero it sets an interrupt-pending flag that drives `irq`. In continuous mode it then reloads and runs on. In single-shot mode it stops at zero and drops the enable bit.

Control signals enter the timer domain through two-flop synchronizers. The reload request and the zero event cross as toggles. The live count returns to the bus domain as a copy that a request/acknowledge loop holds stable, so a read never mixes bits from two different counts. The interval register is treated as quasi-static: software writes it before the control write that requests a reload. A re-enable that follows a disable by fewer than two ticks is refused.

Top module: `dcnt_timer`

## Requirements
- R1: After reset the control, current-value and status registers all read 0, and `irq` is low.
- R2: Register offsets are decoded from address bits 3:2, and address bits 1:0 are ignored. The offsets are control at 0x0, interval at 0x4 (read/write), current value at 0x8 (read-only, writes ignored) and status at 0xC. Control bits 31:5 always read 0.
- R3: The control fields are enable at bit 0, reload at bit 1, prescale select at bits 3:2 and mode at bit 4. Reload reads 1 while a request is outstanding and clears by itself once the timer domain has performed the load. Writing reload again while one is outstanding has no effect.
- R4: While running, the count drops by exactly one per tick from the interval toward zero, and it never changes in a timer cycle without a tick.
- R5: A control write that sets enable and reload together makes the counter load the interval register on the next tick. A write that sets enable without reload leaves the count running on from its present value.
- R6: In continuous mode (bit 4 = 0), the tick after the count reaches zero reloads the interval and counting goes on. The enable bit stays 1.
- R7: In single-shot mode (bit 4 = 1), reaching zero stops the counter at 0 and clears the enable bit. The count does not reload afterwards.
- R8: Prescale select values 0, 1, 2 and 3 produce one tick every 1, 2, 4 and 8 timer clocks.
- R9: If enable is set again after being clear for fewer than 2 ticks, the re-enable is ignored and the count stays frozen. A later enable that follows at least 2 ticks of disable resumes counting.
- R10: Each transition of the count to zero sets status bit 0, and `irq` follows that bit. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R11: The current-value register holds a complete snapshot of the timer-domain count. It changes only when a transfer completes, and it trails the live count by a few clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| tclk | input | 1 | Timer source clock, slower than half of pclk once prescaled |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Bus access strobe, one pclk cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request, high while status bit 0 is set |

## Verification
The checker watches several properties on every cycle. The count moves only on ticks and then steps by one. A load lands the interval value. A stopped single-shot channel sits at zero. The bus-side snapshot changes only on a completed transfer. `irq` rises only after a zero event and falls only after a write-1 clear. Control reads keep their reserved bits at zero. Other behaviours depend on how the two clock domains line up, and only the bench scenarios can show them. These are the refused early re-enable and the later resumption, the difference between restarting with and without reload, the prescale rates, and the continuous versus single-shot endings. The bench judges each of these by windows of acceptable count values.

// File: rtl/dcnt_pkg.sv
`timescale 1ns/1ps
package dcnt_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned RLD_BIT  = 1;
  localparam int unsigned PS_LSB   = 2;
  localparam int unsigned PS_W     = 2;
  localparam int unsigned MODE_BIT = 4;
  localparam int unsigned DIV_W    = 2 ** PS_W - 1;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_IVAL = 2'd1,
    RSEL_CUR  = 2'd2,
    RSEL_STAT = 2'd3
  } rsel_e;

  typedef struct packed {
    logic           mode;
    logic [PS_W-1:0] psel;
    logic           en;
    logic           rld_tog;
  } tctl_t;

  // terminal value of the tick divider for a prescale select
  function automatic logic [DIV_W-1:0] div_last(input logic [PS_W-1:0] sel);
    logic [DIV_W:0] one_hot;
    one_hot = (DIV_W+1)'(1) << sel;
    return DIV_W'(one_hot - (DIV_W+1)'(1));
  endfunction
endpackage

// File: rtl/dcnt_sync.sv
`timescale 1ns/1ps
module dcnt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcnt_prescaler.sv
`timescale 1ns/1ps
module dcnt_prescaler
  import dcnt_pkg::*;
(
  input  logic            tclk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] psel,
  output logic            tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last;

  assign last = div_last(psel);
  // >= so that lowering the select mid-count cannot strand the divider
  assign tick = (div_q >= last);

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/dcnt_xfer.sv
`timescale 1ns/1ps
module dcnt_xfer #(
  parameter int W = 32
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_data,
  output logic [W-1:0] dst_data,
  output logic         cap
);
  logic         req_q, req_s, ack_q, ack_s;
  logic [W-1:0] hold_q;

  dcnt_sync #(.W(1)) u_req_sync (.clk(src_clk), .rst_n(rst_n), .d(req_q), .q(req_s));

  // source side: take a snapshot for every new request, then acknowledge
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ack_q  <= 1'b0;
    end else if (req_s != ack_q) begin
      hold_q <= src_data;
      ack_q  <= req_s;
    end
  end

  dcnt_sync #(.W(1)) u_ack_sync (.clk(dst_clk), .rst_n(rst_n), .d(ack_q), .q(ack_s));

  // destination side: hold_q is stable whenever the acknowledge matches
  assign cap = (ack_s == req_q);

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      dst_data <= '0;
    end else if (cap) begin
      dst_data <= hold_q;
      req_q    <= ~req_q;
    end
  end
endmodule

// File: rtl/dcnt_core.sv
`timescale 1ns/1ps
module dcnt_core #(
  parameter int CNT_W     = 32,
  parameter int GAP_TICKS = 2
) (
  input  logic             tclk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en_s,
  input  logic             mode_s,
  input  logic             rld_tog_s,
  input  logic [CNT_W-1:0] ival,
  output logic [CNT_W-1:0] cnt,
  output logic             ack_tog,
  output logic             zev_tog,
  output logic             ld_evt,
  output logic             adv,
  output logic             run,
  output logic             done
);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic is_last(input logic [CNT_W-1:0] v);
    return v == CNT_W'(1);
  endfunction

  logic [GAP_W-1:0] gap_q;
  logic             en_d, armed_q, done_q, ack_q, zev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ld_pend, rise, gap_ok;

  assign ld_pend = rld_tog_s ^ ack_q;
  assign rise    = en_s & ~en_d;
  assign gap_ok  = (gap_q == GAP_W'(GAP_TICKS));
  assign run     = en_s & armed_q & ~done_q;
  assign ld_evt  = tick & run & ld_pend;
  assign adv     = tick & run & ~ld_pend;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= GAP_W'(GAP_TICKS);
      en_d    <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      zev_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      en_d <= en_s;
      if (!en_s) begin
        armed_q <= 1'b0;
        done_q  <= 1'b0;
        if (tick && !gap_ok) gap_q <= gap_q + GAP_W'(1);
      end else begin
        gap_q <= '0;
        if (rise) armed_q <= gap_ok;
      end

      if (ld_evt) begin
        cnt_q <= ival;
        ack_q <= rld_tog_s;
      end else if (adv) begin
        if (cnt_q == '0) begin
          cnt_q <= ival;
        end else begin
          cnt_q <= step_down(cnt_q);
          if (is_last(cnt_q)) begin
            zev_q <= ~zev_q;
            if (mode_s) done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign cnt     = cnt_q;
  assign ack_tog = ack_q;
  assign zev_tog = zev_q;
  assign done    = done_q;
endmodule

// File: rtl/dcnt_regs.sv
`timescale 1ns/1ps
module dcnt_regs
  import dcnt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_tog_s,
  input  logic              zev_tog_s,
  input  logic [DATA_W-1:0] cur_val,
  output tctl_t             ctl,
  output logic [DATA_W-1:0] ival,
  output logic              zev_pulse,
  output logic              irq
);
  rsel_e            rsel;
  logic             wr_ctrl, wr_ival, wr_stat, rld_busy;
  logic             en_q, mode_q, rld_q, pend_q, zev_d;
  logic [PS_W-1:0]  psel_q;
  logic [DATA_W-1:0] ival_q;
  logic             unused_addr;

  assign rsel        = rsel_e'(bus_addr[3:2]);
  assign unused_addr = ^bus_addr[1:0];
  assign wr_ctrl     = bus_sel & bus_wr & (rsel == RSEL_CTRL);
  assign wr_ival     = bus_sel & bus_wr & (rsel == RSEL_IVAL);
  assign wr_stat     = bus_sel & bus_wr & (rsel == RSEL_STAT);
  assign rld_busy    = rld_q ^ ack_tog_s;
  assign zev_pulse   = zev_d ^ zev_tog_s;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      psel_q <= '0;
      rld_q  <= 1'b0;
      ival_q <= '0;
      pend_q <= 1'b0;
      zev_d  <= 1'b0;
    end else begin
      zev_d <= zev_tog_s;
      if (wr_ctrl) begin
        en_q   <= bus_wdata[EN_BIT];
        mode_q <= bus_wdata[MODE_BIT];
        psel_q <= bus_wdata[PS_LSB +: PS_W];
        if (bus_wdata[RLD_BIT] && !rld_busy) rld_q <= ~rld_q;
      end else if (zev_pulse && mode_q) begin
        en_q <= 1'b0;
      end
      if (wr_ival) ival_q <= bus_wdata;
      if (zev_pulse)                         pend_q <= 1'b1;
      else if (wr_stat && bus_wdata[0])      pend_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_CTRL: bus_rdata = DATA_W'({mode_q, psel_q, rld_busy, en_q});
      RSEL_IVAL: bus_rdata = ival_q;
      RSEL_CUR:  bus_rdata = cur_val;
      RSEL_STAT: bus_rdata = DATA_W'(pend_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign ctl.mode    = mode_q;
  assign ctl.psel    = psel_q;
  assign ctl.en      = en_q;
  assign ctl.rld_tog = rld_q;
  assign ival        = ival_q;
  assign irq         = pend_q;
endmodule

// File: rtl/dcnt_timer.sv
`timescale 1ns/1ps
module dcnt_timer
  import dcnt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int GAP_TICKS = 2
) (
  input  logic              pclk,
  input  logic              tclk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CTL_W = $bits(tctl_t);

  tctl_t             ctl_p, ctl_t;
  logic [DATA_W-1:0] ival_w, cnt_w, cur_w;
  logic              tick_w, run_w, adv_w, ld_evt_w, done_w;
  logic              ack_tog_t, zev_tog_t, ack_tog_p, zev_tog_p;
  logic              zev_pulse_w, cap_w;

  dcnt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .pclk(pclk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_tog_s(ack_tog_p), .zev_tog_s(zev_tog_p), .cur_val(cur_w),
    .ctl(ctl_p), .ival(ival_w), .zev_pulse(zev_pulse_w), .irq(irq)
  );

  dcnt_sync #(.W(CTL_W)) u_ctl_sync (
    .clk(tclk), .rst_n(rst_n), .d(ctl_p), .q(ctl_t)
  );

  dcnt_prescaler u_presc (
    .tclk(tclk), .rst_n(rst_n), .psel(ctl_t.psel), .tick(tick_w)
  );

  dcnt_core #(.CNT_W(DATA_W), .GAP_TICKS(GAP_TICKS)) u_core (
    .tclk(tclk), .rst_n(rst_n), .tick(tick_w),
    .en_s(ctl_t.en), .mode_s(ctl_t.mode), .rld_tog_s(ctl_t.rld_tog),
    .ival(ival_w), .cnt(cnt_w), .ack_tog(ack_tog_t), .zev_tog(zev_tog_t),
    .ld_evt(ld_evt_w), .adv(adv_w), .run(run_w), .done(done_w)
  );

  dcnt_sync #(.W(2)) u_evt_sync (
    .clk(pclk), .rst_n(rst_n), .d({ack_tog_t, zev_tog_t}), .q({ack_tog_p, zev_tog_p})
  );

  dcnt_xfer #(.W(DATA_W)) u_xfer (
    .src_clk(tclk), .dst_clk(pclk), .rst_n(rst_n),
    .src_data(cnt_w), .dst_data(cur_w), .cap(cap_w)
  );
endmodule

// File: rtl/dcnt_checker.sv
`timescale 1ns/1ps
module dcnt_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              pclk,
  input logic              tclk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick,
  input logic              adv,
  input logic              ld_evt,
  input logic              done,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] ival,
  input logic              zev_pulse,
  input logic              cap,
  input logic [DATA_W-1:0] cur
);
  a_r2_ctrl_reserved_zero: assert property (@(posedge pclk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[3:2] == 2'b00) |-> (bus_rdata[DATA_W-1:5] == '0));

  a_r4_still_without_tick: assert property (@(posedge tclk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r4_step_by_one: assert property (@(posedge tclk) disable iff (!rst_n)
    (adv && cnt != '0) |=> (cnt == $past(cnt) - DATA_W'(1)));

  a_r5_load_lands_interval: assert property (@(posedge tclk) disable iff (!rst_n)
    ld_evt |=> (cnt == $past(ival)));

  a_r7_stopped_at_zero: assert property (@(posedge tclk) disable iff (!rst_n)
    done |-> (cnt == '0));

  a_r10_irq_after_zero: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(irq) |-> $past(zev_pulse));

  a_r10_irq_clear_by_write: assert property (@(posedge pclk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_sel && bus_wr && bus_addr[3:2] == 2'b11 && bus_wdata[0]));

  a_r11_snapshot_held: assert property (@(posedge pclk) disable iff (!rst_n)
    !cap |=> $stable(cur));
endmodule

bind dcnt_timer dcnt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .pclk(pclk), .tclk(tclk), .rst_n(rst_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .tick(tick_w), .adv(adv_w), .ld_evt(ld_evt_w), .done(done_w),
  .cnt(cnt_w), .ival(ival_w), .zev_pulse(zev_pulse_w),
  .cap(cap_w), .cur(cur_w)
);

// File: tb/dcnt_timer_tb_top.sv
`timescale 1ns/1ps
module dcnt_timer_tb_top;
  localparam logic [3:0] A_CTRL = 4'h0, A_IVAL = 4'h4, A_CUR = 4'h8, A_STAT = 4'hC;

  logic        pclk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, peek_on = 1'b0, finished = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2.5 pclk = ~pclk;
  always #10  tclk = ~tclk;

  dcnt_timer dut_i (
    .pclk(pclk), .tclk(tclk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge pclk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge pclk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read the monitor will judge
  task automatic expect_rd(input logic [3:0] a, input logic [31:0] lo, input logic [31:0] hi, input string tag);
    exp_t e;
    e.addr = a; e.lo = lo; e.hi = hi; e.tag = tag;
    sb_q.push_back(e);
    @(negedge pclk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge pclk);
    bus_sel = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    @(negedge pclk);
    peek_on = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge pclk);
    bus_sel = 1'b0; peek_on = 1'b0;
  endtask

  task automatic check_irq(input logic exp, input string tag);
    @(negedge pclk);
    #1 check(irq === exp, tag, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic wait_t(input int n);
    repeat (n) @(negedge tclk);
  endtask

  // monitor: compare each read against the front of the scoreboard
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge pclk);
      #1;
      if (bus_sel && !bus_wr && !peek_on) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "scoreboard underflow", bus_rdata, 32'd0);
        end else begin
          e = sb_q.pop_front();
          n_chk++;
          if (bus_rdata < e.lo || bus_rdata > e.hi || bus_addr != e.addr) begin
            n_fail++;
            $display("FAIL %s addr=0x%0h actual=%0d expected=[%0d..%0d]",
                     e.tag, bus_addr, bus_rdata, e.lo, e.hi);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge pclk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v1, v2;
    repeat (4) @(negedge pclk);
    rst_n = 1'b1;
    repeat (2) @(negedge pclk);

    // R1 reset values
    expect_rd(A_CTRL, 0, 0, "R1 control after reset");
    expect_rd(A_CUR,  0, 0, "R1 current after reset");
    expect_rd(A_STAT, 0, 0, "R1 status after reset");
    check_irq(1'b0, "R1 irq after reset");

    // R2 map, reserved bits, low address bits, read-only current value
    bus_write(A_IVAL, 32'd20);
    expect_rd(A_IVAL, 20, 20, "R2 interval readback");
    expect_rd(4'h5, 20, 20, "R2 address bits 1:0 ignored");
    bus_write(A_CUR, 32'h1234);
    expect_rd(A_CUR, 0, 0, "R2 current value write ignored");
    bus_write(A_CTRL, 32'hFFFF_FFEC);
    expect_rd(A_CTRL, 32'hC, 32'hC, "R2 R3 reserved bits zero, prescale field kept");
    bus_write(A_CTRL, 32'h0);
    wait_t(6);

    // R4 R5 R6 R10 continuous run, interval 20, prescale 1
    bus_write(A_CTRL, 32'h3);
    wait_t(10);
    expect_rd(A_CUR, 8, 20, "R4 R5 counting down from loaded interval");
    expect_rd(A_CTRL, 1, 1, "R3 reload bit self-cleared");
    wait_t(40);
    expect_rd(A_STAT, 1, 1, "R10 pending after zero");
    check_irq(1'b1, "R10 irq follows pending");
    expect_rd(A_CTRL, 1, 1, "R6 enable stays set in continuous mode");
    expect_rd(A_CUR, 0, 20, "R6 count stays within interval");
    bus_write(A_STAT, 32'h0);
    expect_rd(A_STAT, 1, 1, "R10 writing 0 leaves pending");
    bus_write(A_STAT, 32'h1);
    expect_rd(A_STAT, 0, 0, "R10 write 1 clears pending");
    check_irq(1'b0, "R10 irq low after clear");
    wait_t(25);
    expect_rd(A_STAT, 1, 1, "R6 reload gives another zero event");

    // R5 reload versus plain enable
    bus_write(A_CTRL, 32'h0);
    wait_t(6);
    bus_write(A_IVAL, 32'd1000);
    bus_write(A_CTRL, 32'h3);
    wait_t(20);
    expect_rd(A_CUR, 975, 1000, "R5 loaded 1000");
    bus_write(A_IVAL, 32'd300);
    bus_write(A_CTRL, 32'h1);
    wait_t(10);
    expect_rd(A_CUR, 950, 1000, "R5 enable without reload keeps counting");
    bus_write(A_CTRL, 32'h3);
    wait_t(10);
    expect_rd(A_CUR, 285, 300, "R5 enable with reload loads new interval");

    // R8 prescale divide by 8 and by 2
    bus_write(A_CTRL, 32'h0);
    wait_t(6);
    bus_write(A_IVAL, 32'd100);
    bus_write(A_CTRL, 32'hF);
    wait_t(160);
    expect_rd(A_CUR, 76, 86, "R8 divide by 8 rate");
    bus_write(A_CTRL, 32'h0);
    wait_t(10);
    bus_write(A_CTRL, 32'h7);
    wait_t(80);
    expect_rd(A_CUR, 58, 68, "R8 divide by 2 rate");

    // R9 early re-enable refused, later one accepted
    bus_write(A_CTRL, 32'h0);
    wait_t(20);
    bus_write(A_IVAL, 32'd500);
    bus_write(A_CTRL, 32'hF);
    wait_t(40);
    bus_write(A_CTRL, 32'hC);
    wait_t(3);
    bus_write(A_CTRL, 32'hD);
    wait_t(10);
    peek(A_CUR, v1);
    check(v1 >= 32'd480 && v1 <= 32'd500, "R9 count before freeze", v1, 32'd495);
    wait_t(40);
    expect_rd(A_CUR, v1, v1, "R9 early re-enable leaves count frozen");
    bus_write(A_CTRL, 32'hC);
    wait_t(40);
    bus_write(A_CTRL, 32'hD);
    wait_t(40);
    expect_rd(A_CUR, v1 - 32'd6, v1 - 32'd2, "R9 re-enable after gap resumes");
    peek(A_CUR, v2);
    wait_t(2);
    expect_rd(A_CUR, v2 - 32'd1, v2, "R11 snapshot tracks live count");

    // R7 single-shot
    bus_write(A_CTRL, 32'h0);
    wait_t(6);
    bus_write(A_STAT, 32'h1);
    bus_write(A_IVAL, 32'd10);
    bus_write(A_CTRL, 32'h13);
    wait_t(30);
    expect_rd(A_CTRL, 32'h10, 32'h10, "R7 enable cleared at zero");
    expect_rd(A_CUR, 0, 0, "R7 stopped at zero");
    expect_rd(A_STAT, 1, 1, "R7 R10 single-shot sets pending");
    check_irq(1'b1, "R7 irq after single-shot");
    bus_write(A_CUR, 32'd5);
    wait_t(20);
    expect_rd(A_CUR, 0, 0, "R7 no reload after stop, R2 write ignored");

    repeat (6) @(negedge pclk);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule